// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block turns the fill state of a 16550-style UART's receive and transmit FIFOs into two one-clock request strobes for a DMA engine. The receive strobe tells the engine to drain characters from the receive buffer. The transmit strobe tells it to refill the transmit holding register.

Every strobe comes from the rising edge of a condition. A level that stays true does not repeat the strobe, and nothing is queued. A strobe that the DMA engine misses is gone until a new condition arises.

The receive side compares the FIFO fill with a programmable trigger level. It also accepts a one-cycle character-timeout strobe. A character flagged with an error at the FIFO head holds back both sources. The transmit side fires when the transmit FIFO drains to empty, and when the transmitter is released from reset. With FIFO mode off, both strobes stay quiet.

The FIFOs, shifters and DMA engine sit outside the block and are seen only through occupancy counts and flags. Each strobe is registered, so it appears one clock after the input condition is presented.

Top module: `uart_dma_evt`

## Requirements
- R1: The trigger selector `rx_trig_sel` encodes the receive trigger level as 0 → 1, 1 → 4, 2 → 8, 3 → 14 characters. `rx_evt` pulses high for one cycle, one clock after `rx_count` first reaches or exceeds the selected level.
- R2: While the fill stays at or above the trigger, no further `rx_evt` comes from the level. The fill must drop below the trigger, then reach it again, for the next one.
- R3: A `rx_timeout` strobe with `rx_count` nonzero produces an `rx_evt` one clock later, even below the trigger. With `rx_count` zero, the timeout is ignored.
- R4: While `rx_head_err` is 1, no `rx_evt` is produced from either source. Once the flag clears, a fill still at or above the trigger produces an `rx_evt`.
- R5: With FIFO mode on and the transmitter running, `tx_evt` pulses one clock after `tx_count` changes from nonzero to zero. A count that stays at zero gives no further pulse.
- R6: A 0 → 1 transition of `tx_run` while `fifo_en` is 1 produces a `tx_evt` one clock later. While `tx_run` is 0, `tx_evt` stays 0.
- R7: While `fifo_en` is 0, neither `rx_evt` nor `tx_evt` is ever asserted.
- R8: Clearing `fifo_en` discards the edge history, so re-enabling with the fill already above the trigger, or with an empty transmit FIFO, produces no strobe. Holding `tx_run` at 0 does the same for the transmit-empty history.
- R9: Synchronous active-high `rst` drives both strobes to 0. After reset, a fill or an empty transmit FIFO that is already present does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO mode enable |
| rx_trig_sel | input | 2 | Receive trigger level selector |
| rx_count | input | CNT_W (5) | Receive FIFO occupancy |
| rx_head_err | input | 1 | Error flag of the character at the receive FIFO head |
| rx_timeout | input | 1 | One-cycle character-timeout strobe |
| tx_count | input | CNT_W (5) | Transmit FIFO occupancy |
| tx_run | input | 1 | Transmitter out of reset (1) or held in reset (0) |
| rx_evt | output | 1 | Receive DMA request strobe |
| tx_evt | output | 1 | Transmit DMA request strobe |

## Verification
Directed ramps of the receive fill through every trigger setting tell a correct threshold apart from an off-by-one one. Holding the fill and bouncing it across the trigger shows that the receive strobe is edge-based and does not repeat. Timeout strobes are applied at zero and nonzero fill, and head errors are set and cleared over a full FIFO. Together these separate the receive sources and show where the error gate sits.

On the transmit side, drain sequences, reset releases and enable toggles distinguish the empty transition from the release event and from stale history. A long random walk of all inputs, compared against a cycle model, mixes these conditions in orders the directed cases do not reach.

// File: rtl/uart_dma_evt_pkg.sv
package uart_dma_evt_pkg;

    localparam int FIFO_DEPTH = 16;

    typedef enum logic [1:0] {
        TRIG_ONE       = 2'd0,
        TRIG_QUARTER   = 2'd1,
        TRIG_HALF      = 2'd2,
        TRIG_NEAR_FULL = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic head_err;
        logic timeout;
        logic nonempty;
        logic at_trigger;
    } rx_view_t;

    // Trigger level in characters for a FIFO of the given depth.
    function automatic int trig_level(trig_sel_e sel, int depth);
        case (sel)
            TRIG_ONE:       return 1;
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            default:        return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
    parameter bit INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic level,
    output logic rise
);
    logic seen_q;

    // A clear marks the level as already seen, so no edge survives it.
    always_ff @(posedge clk) begin
        if (rst)        seen_q <= INIT;
        else if (clear) seen_q <= 1'b1;
        else            seen_q <= level;
    end

    assign rise = level & ~seen_q & ~clear;
endmodule

// File: rtl/rx_evt_gen.sv
module rx_evt_gen
    import uart_dma_evt_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] count,
    input  logic             head_err,
    input  logic             timeout,
    output logic             evt
);
    logic [CNT_W-1:0] thresh;
    rx_view_t         view;
    logic             level_ok;
    logic             level_rise;
    logic             to_hit;

    assign thresh = CNT_W'(trig_level(trig_sel_e'(sel), DEPTH));

    always_comb begin
        view.head_err   = head_err;
        view.timeout    = timeout;
        view.nonempty   = (count != '0);
        view.at_trigger = (count >= thresh);
    end

    assign level_ok = view.at_trigger & ~view.head_err;
    assign to_hit   = view.timeout & view.nonempty & ~view.head_err;

    evt_edge_det #(.INIT(1'b1)) u_lvl (
        .clk   (clk),
        .rst   (rst),
        .clear (~enable),
        .level (level_ok),
        .rise  (level_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= enable & (level_rise | to_hit);
    end
endmodule

// File: rtl/tx_evt_gen.sv
module tx_evt_gen #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    output logic             evt
);
    logic active;
    logic empty_rise;
    logic run_rise;

    assign active = enable & run;

    evt_edge_det #(.INIT(1'b1)) u_empty (
        .clk   (clk),
        .rst   (rst),
        .clear (~active),
        .level (count == '0),
        .rise  (empty_rise)
    );

    evt_edge_det #(.INIT(1'b1)) u_release (
        .clk   (clk),
        .rst   (rst),
        .clear (1'b0),
        .level (run),
        .rise  (run_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= active & (empty_rise | run_rise);
    end
endmodule

// File: rtl/uart_dma_evt.sv
module uart_dma_evt
    import uart_dma_evt_pkg::*;
#(
    parameter  int DEPTH = FIFO_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_head_err,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_run,
    output logic             rx_evt,
    output logic             tx_evt
);
    rx_evt_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .enable   (fifo_en),
        .sel      (rx_trig_sel),
        .count    (rx_count),
        .head_err (rx_head_err),
        .timeout  (rx_timeout),
        .evt      (rx_evt)
    );

    tx_evt_gen #(.CNT_W(CNT_W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .enable (fifo_en),
        .run    (tx_run),
        .count  (tx_count),
        .evt    (tx_evt)
    );
endmodule

// File: rtl/uart_dma_evt_chk.sv
module uart_dma_evt_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_head_err,
    input logic             tx_run,
    input logic             rx_evt,
    input logic             tx_evt
);
    logic             valid_q;
    logic             en_q;
    logic             err_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            run_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            valid_q <= 1'b1;
            en_q    <= fifo_en;
            err_q   <= rx_head_err;
            run_q   <= tx_run;
            cnt_q   <= rx_count;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !en_q) |-> (!rx_evt && !tx_evt)); // R7
    AST_RX_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (valid_q && cnt_q == '0) |-> !rx_evt); // R3
    AST_RX_HEAD_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (valid_q && err_q) |-> !rx_evt); // R4
    AST_TX_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !run_q) |-> !tx_evt); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (valid_q == 1'b0) |-> (!rx_evt && !tx_evt)); // R9
endmodule

bind uart_dma_evt uart_dma_evt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_en     (fifo_en),
    .rx_count    (rx_count),
    .rx_head_err (rx_head_err),
    .tx_run      (tx_run),
    .rx_evt      (rx_evt),
    .tx_evt      (tx_evt)
);

// File: tb/sim_uart_dma_evt.sv
`timescale 1ns/1ps
module sim_uart_dma_evt;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 1'b0;
    logic [1:0]    rx_trig_sel = 2'd0;
    logic [CW-1:0] rx_count = '0;
    logic          rx_head_err = 1'b0;
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic          tx_run = 1'b0;
    logic          rx_evt;
    logic          tx_evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_rxq    = 1'b1;
    bit m_emq    = 1'b1;
    bit m_runq   = 1'b1;

    always #10 clk = ~clk;

    uart_dma_evt u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel),
        .rx_count(rx_count), .rx_head_err(rx_head_err), .rx_timeout(rx_timeout),
        .tx_count(tx_count), .tx_run(tx_run), .rx_evt(rx_evt), .tx_evt(tx_evt)
    );

    function automatic int trig(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, predict, sample at the next falling edge.
    task automatic step(input bit en, input logic [1:0] sel, input int rc, input bit err,
                        input bit to, input int tc, input bit run, input string tag);
        bit lvl, erx, act, etx;
        fifo_en = en; rx_trig_sel = sel; rx_count = CW'(rc); rx_head_err = err;
        rx_timeout = to; tx_count = CW'(tc); tx_run = run;
        lvl = (rc >= trig(sel)) && !err;
        erx = en && ((lvl && !m_rxq) || (to && rc != 0 && !err));
        m_rxq = en ? lvl : 1'b1;
        act = en && run;
        etx = act && (((tc == 0) && !m_emq) || !m_runq);
        m_emq = act ? (tc == 0) : 1'b1;
        m_runq = run;
        @(posedge clk); @(negedge clk);
        check(tag, rx_evt, erx, "rx_evt");
        check(tag, tx_evt, etx, "tx_evt");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        m_rxq = 1'b1; m_emq = 1'b1; m_runq = 1'b1;
        check("R9", rx_evt, 1'b0, "rx_evt in reset");
        check("R9", tx_evt, 1'b0, "tx_evt in reset");
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int rc, tc;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        // R9: condition present at reset release does not fire
        step(1, 2'd0, 5, 0, 0, 0, 1, "R9");
        // R1/R2: threshold 4
        for (int i = 0; i <= 6; i++) step(1, 2'd1, i, 0, 0, 0, 1, "R1");
        step(1, 2'd1, 6, 0, 0, 0, 1, "R2");
        step(1, 2'd1, 3, 0, 0, 0, 1, "R2");
        step(1, 2'd1, 4, 0, 0, 0, 1, "R2");
        // R1: threshold 14 and 8
        step(1, 2'd3, 0, 0, 0, 0, 1, "R1");
        step(1, 2'd3, 13, 0, 0, 0, 1, "R1");
        step(1, 2'd3, 14, 0, 0, 0, 1, "R1");
        step(1, 2'd2, 7, 0, 0, 0, 1, "R1");
        step(1, 2'd2, 8, 0, 0, 0, 1, "R1");
        // R3: timeout below trigger, and at empty
        step(1, 2'd2, 2, 0, 1, 0, 1, "R3");
        step(1, 2'd2, 0, 0, 1, 0, 1, "R3");
        step(1, 2'd2, 0, 0, 0, 0, 1, "R3");
        // R4: head error gate then release
        step(1, 2'd0, 3, 1, 0, 0, 1, "R4");
        step(1, 2'd0, 3, 1, 1, 0, 1, "R4");
        step(1, 2'd0, 2, 0, 0, 0, 1, "R4");
        // R5: transmit drain
        step(1, 2'd0, 0, 0, 0, 3, 1, "R5");
        step(1, 2'd0, 0, 0, 0, 1, 1, "R5");
        step(1, 2'd0, 0, 0, 0, 0, 1, "R5");
        step(1, 2'd0, 0, 0, 0, 0, 1, "R5");
        // R6/R8: transmitter reset and release
        step(1, 2'd0, 0, 0, 0, 2, 0, "R6");
        step(1, 2'd0, 0, 0, 0, 0, 0, "R8");
        step(1, 2'd0, 0, 0, 0, 0, 1, "R6");
        // R7: FIFO mode off
        step(0, 2'd0, 9, 0, 1, 4, 1, "R7");
        step(0, 2'd0, 9, 0, 0, 0, 1, "R7");
        step(0, 2'd0, 9, 0, 0, 0, 0, "R7");
        step(0, 2'd0, 9, 0, 0, 0, 1, "R7");
        // R8: re-enable without stale events
        step(1, 2'd0, 9, 0, 0, 0, 1, "R8");
        step(1, 2'd0, 0, 0, 0, 0, 1, "R8");
        step(1, 2'd0, 1, 0, 0, 0, 1, "R8");
        // Random walk
        rc = 0; tc = 0;
        for (int k = 0; k < 4000; k++) begin
            bit en, err, to, run;
            rc = rc + int'($urandom_range(0, 2)) - 1;
            if (rc < 0) rc = 0;
            if (rc > 16) rc = 16;
            tc = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 16));
            en  = ($urandom_range(0, 15) != 0);
            err = ($urandom_range(0, 7) == 0);
            to  = ($urandom_range(0, 9) == 0);
            run = ($urandom_range(0, 11) != 0);
            step(en, 2'($urandom_range(0, 3)), rc, err, to, tc, run, "R1-mix");
        end
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule